// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Interrupt Combiner

This block serialises bytes onto a single transmit pin. A write-only register bus has two locations. Select 0 is a control register and select 1 is a one-word holding register. A shift engine moves each held word into its shift register and sends it as an asynchronous frame, timed by an external oversampling tick. While one frame is on the line, the holding register can already take the next word, so frames can follow each other with no gap beyond the stop bit.

The block keeps two flags. The holding-empty flag is set when the holding register can accept a word. The line-done flag is set when the transmitter has finished and has nothing left to send. Three receiver status inputs (overrun, receive full and idle) come from elsewhere. The block gates them, together with its own two flags, by four enable bits and combines the result into one interrupt line.

Clearing the transmit enable and setting it again while a frame is in flight makes the transmitter send a whole idle frame (a preamble) after the current frame. Setting the enable from the idle state holds the line high for one bit time before any frame starts. When neither the transmitter nor the receiver is enabled, the pin is handed over to a general-purpose output value.

Top module: `sertx_top`

## Requirements
- R1: After reset, the control register reads 0x00, holding-empty is 1, line-done is 1 and irq is 0.
- R2: A frame has a start bit (0), then 8 data bits with the least significant bit first, then a stop bit (1). Each bit lasts 16 baud ticks. The line idles at 1.
- R3: A write to select 1 clears holding-empty. The flag sets again when the word moves into the shift register.
- R4: Line-done sets when a stop bit or a preamble ends while holding-empty is 1. A write to select 1 clears it. While line-done is 1, the serial line is high.
- R5: Control bit 7 enables the interrupt term "holding-empty is 1". Control bit 6 enables the term "line-done is 1". With all enable bits (7:4) at 0, irq is 0.
- R6: Control bit 5 enables the interrupt term "rx_overrun or rx_full". Control bit 4 enables the term "rx_idle". irq is the OR of all enabled terms.
- R7: When control bit 3 (transmit enable) goes from 0 to 1 while the transmitter is idle, the line stays high for one bit time (16 ticks) before the first start bit.
- R8: If transmit enable is cleared and then set again during a frame, that frame completes. A 10-bit-time idle preamble then precedes the next frame.
- R9: tx_drive is 1 when either transmit enable or rx_enable is 1. When both are 0, tx_drive is 0 and tx_pin follows gpio_out.
- R10: A word written while a frame is in flight is sent directly after that frame's stop bit, with no extra idle time.
- R11: Control bits 2:0 are not stored and always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 holding data |
| bus_wdata | input | BUS_W | Write data |
| baud_tick | input | 1 | Oversampling tick, one cycle wide |
| rx_enable | input | 1 | Receiver enabled (claims the pin) |
| rx_overrun | input | 1 | Receiver overrun flag |
| rx_full | input | 1 | Receiver data-full flag |
| rx_idle | input | 1 | Receiver idle-line flag |
| gpio_out | input | 1 | General-purpose value for the released pin |
| ctrl_q | output | 8 | Current control register |
| tdr_empty | output | 1 | Holding register empty flag |
| tx_complete | output | 1 | Line-done flag |
| tx_pin | output | 1 | Transmit pin value |
| tx_drive | output | 1 | Transmitter owns the pin |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume three things about the inputs: bus_wr is a single-cycle strobe, baud_tick is a single-cycle pulse, and the receiver flags may change on any cycle. They also assume that data writes never land in the same cycle as reset release. The bench drives a tick on every second clock and issues each write as one strobe between falling edges. It changes the receiver flags only while it is checking irq combinations, and a scoreboard queue holds the words that are expected to appear on the pin.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   localparam int unsigned CTRL_W  = 8;
   localparam int unsigned CB_TIE  = 7;
   localparam int unsigned CB_TCIE = 6;
   localparam int unsigned CB_RIE  = 5;
   localparam int unsigned CB_ILIE = 4;
   localparam int unsigned CB_TEN  = 3;
   localparam int unsigned N_IRQ   = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DELAY,
      ST_START,
      ST_DATA,
      ST_STOP,
      ST_PREAMBLE
   } tx_state_e;
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
   import sertx_pkg::*;
#(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_sel,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              load_p,
   input  logic              done_p,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] hold_q,
   output logic              hold_empty,
   output logic              done_flag
);
   localparam int unsigned STORED_LO = CB_TEN;

   logic wr_ctrl, wr_data;
   assign wr_ctrl = bus_wr && !bus_sel;
   assign wr_data = bus_wr &&  bus_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= {bus_wdata[CTRL_W-1:STORED_LO], {STORED_LO{1'b0}}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (wr_data) begin
         hold_q <= bus_wdata[DATA_W-1:0];
      end
   end

   // A write wins over a same-cycle load or done pulse.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_empty <= 1'b1;
      end else if (wr_data) begin
         hold_empty <= 1'b0;
      end else if (load_p) begin
         hold_empty <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_flag <= 1'b1;
      end else if (wr_data) begin
         done_flag <= 1'b0;
      end else if (done_p) begin
         done_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_en,
   input  logic [DATA_W-1:0] hold_q,
   input  logic              hold_empty,
   output logic              load_p,
   output logic              done_p,
   output logic              line
);
   localparam int unsigned FRAME_BITS = DATA_W + 2;
   localparam int unsigned CNT_W      = (OSR > 1) ? $clog2(OSR) : 1;
   localparam int unsigned BIT_W      = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
   localparam logic [BIT_W-1:0] DAT_LAST = BIT_W'(DATA_W - 1);
   localparam logic [BIT_W-1:0] PRE_LAST = BIT_W'(FRAME_BITS - 1);

   tx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [DATA_W-1:0] shreg;
   logic              pre_pend;
   logic              en_d;
   logic              en_rise, busy, bit_end, have_word, pre_now;

   assign en_rise   = tx_en && !en_d;
   assign busy      = (state == ST_START) || (state == ST_DATA) || (state == ST_STOP);
   assign bit_end   = baud_tick && (cnt == CNT_LAST);
   assign have_word = tx_en && !hold_empty;
   assign pre_now   = pre_pend || (en_rise && busy);

   always_comb begin
      load_p = 1'b0;
      done_p = 1'b0;
      unique case (state)
         ST_IDLE:     load_p = have_word && !en_rise;
         ST_STOP: begin
            load_p = bit_end && !pre_now && have_word;
            done_p = bit_end && !pre_now && hold_empty;
         end
         ST_PREAMBLE: begin
            load_p = bit_end && (bitn == PRE_LAST) && have_word;
            done_p = bit_end && (bitn == PRE_LAST) && hold_empty;
         end
         default: ;
      endcase
   end

   always_comb begin
      unique case (state)
         ST_START: line = 1'b0;
         ST_DATA:  line = shreg[0];
         default:  line = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d <= 1'b0;
      end else begin
         en_d <= tx_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (state == ST_IDLE || load_p) begin
         cnt <= '0;
      end else if (baud_tick) begin
         cnt <= bit_end ? '0 : cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitn     <= '0;
         shreg    <= '0;
         pre_pend <= 1'b0;
      end else begin
         if (en_rise && busy) begin
            pre_pend <= 1'b1;
         end
         if (load_p) begin
            shreg <= hold_q;
         end
         unique case (state)
            ST_IDLE: begin
               if (en_rise) begin
                  state <= ST_DELAY;
               end else if (load_p) begin
                  state <= ST_START;
               end
            end
            ST_DELAY: begin
               if (!tx_en || bit_end) begin
                  state <= ST_IDLE;
               end
            end
            ST_START: begin
               if (bit_end) begin
                  state <= ST_DATA;
                  bitn  <= '0;
               end
            end
            ST_DATA: begin
               if (bit_end) begin
                  shreg <= shreg >> 1;
                  if (bitn == DAT_LAST) begin
                     state <= ST_STOP;
                  end else begin
                     bitn <= bitn + 1'b1;
                  end
               end
            end
            ST_STOP: begin
               if (bit_end) begin
                  if (pre_now) begin
                     state    <= ST_PREAMBLE;
                     bitn     <= '0;
                     pre_pend <= 1'b0;
                  end else if (load_p) begin
                     state <= ST_START;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_PREAMBLE: begin
               if (bit_end) begin
                  if (bitn == PRE_LAST) begin
                     state <= load_p ? ST_START : ST_IDLE;
                  end else begin
                     bitn <= bitn + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sertx_irq.sv
module sertx_irq
   import sertx_pkg::*;
(
   input  logic [CTRL_W-1:0] ctrl_q,
   input  logic              hold_empty,
   input  logic              done_flag,
   input  logic              rx_overrun,
   input  logic              rx_full,
   input  logic              rx_idle,
   output logic              irq
);
   logic [N_IRQ-1:0] src, en, term;

   assign src = {hold_empty, done_flag, rx_overrun | rx_full, rx_idle};
   assign en  = ctrl_q[CB_TIE:CB_ILIE];

   for (genvar g = 0; g < N_IRQ; g++) begin : g_term
      assign term[g] = src[g] & en[g];
   end

   assign irq = |term;
endmodule

// File: rtl/sertx_top.sv
module sertx_top
   import sertx_pkg::*;
#(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_sel,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              baud_tick,
   input  logic              rx_enable,
   input  logic              rx_overrun,
   input  logic              rx_full,
   input  logic              rx_idle,
   input  logic              gpio_out,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              tdr_empty,
   output logic              tx_complete,
   output logic              tx_pin,
   output logic              tx_drive,
   output logic              irq
);
   if (BUS_W < CTRL_W) begin : g_bad_bus
      $error("BUS_W must hold the control register");
   end
   if (DATA_W > BUS_W || DATA_W < 5) begin : g_bad_data
      $error("DATA_W must be between 5 and BUS_W");
   end
   if (OSR < 2) begin : g_bad_osr
      $error("OSR must be at least 2");
   end

   logic [DATA_W-1:0] hold_q;
   logic              load_p, done_p, line_w;

   sertx_regs #(.BUS_W(BUS_W), .DATA_W(DATA_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_sel    (bus_sel),
      .bus_wdata  (bus_wdata),
      .load_p     (load_p),
      .done_p     (done_p),
      .ctrl_q     (ctrl_q),
      .hold_q     (hold_q),
      .hold_empty (tdr_empty),
      .done_flag  (tx_complete)
   );

   sertx_shifter #(.DATA_W(DATA_W), .OSR(OSR)) shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_tick  (baud_tick),
      .tx_en      (ctrl_q[CB_TEN]),
      .hold_q     (hold_q),
      .hold_empty (tdr_empty),
      .load_p     (load_p),
      .done_p     (done_p),
      .line       (line_w)
   );

   sertx_irq irq_i (
      .ctrl_q     (ctrl_q),
      .hold_empty (tdr_empty),
      .done_flag  (tx_complete),
      .rx_overrun (rx_overrun),
      .rx_full    (rx_full),
      .rx_idle    (rx_idle),
      .irq        (irq)
   );

   assign tx_drive = ctrl_q[CB_TEN] | rx_enable;
   assign tx_pin   = tx_drive ? line_w : gpio_out;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
   import sertx_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_sel,
   input logic              rx_enable,
   input logic              rx_overrun,
   input logic              rx_full,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic              tdr_empty,
   input logic              tx_complete,
   input logic              tx_drive,
   input logic              irq,
   input logic              line_w
);
   AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel) |=> !tdr_empty); // R3
   AST_WR_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel) |=> !tx_complete); // R4
   AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      tx_complete |-> line_w); // R4
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CB_TIE:CB_ILIE] == '0) |-> !irq); // R5
   AST_EMPTY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CB_TIE] && tdr_empty) |-> irq); // R5
   AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CB_RIE] && (rx_overrun || rx_full)) |-> irq); // R6
   AST_PIN_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CB_TEN] || rx_enable) |-> tx_drive); // R9
   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[2:0] == 3'b000); // R11
endmodule

bind sertx_top sertx_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_sel     (bus_sel),
   .rx_enable   (rx_enable),
   .rx_overrun  (rx_overrun),
   .rx_full     (rx_full),
   .ctrl_q      (ctrl_q),
   .tdr_empty   (tdr_empty),
   .tx_complete (tx_complete),
   .tx_drive    (tx_drive),
   .irq         (irq),
   .line_w      (line_w)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_sel = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       baud_tick = 1'b0;
   logic       rx_enable = 1'b0;
   logic       rx_overrun = 1'b0;
   logic       rx_full = 1'b0;
   logic       rx_idle = 1'b0;
   logic       gpio_out = 1'b0;
   logic [7:0] ctrl_q;
   logic       tdr_empty, tx_complete, tx_pin, tx_drive, irq;

   int checks = 0;
   int errors = 0;
   int last_gap = 0;
   logic [7:0] exp_q[$];
   logic div = 1'b0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      div       <= ~div;
      baud_tick <= div;
   end

   sertx_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .baud_tick(baud_tick), .rx_enable(rx_enable),
      .rx_overrun(rx_overrun), .rx_full(rx_full), .rx_idle(rx_idle),
      .gpio_out(gpio_out), .ctrl_q(ctrl_q), .tdr_empty(tdr_empty),
      .tx_complete(tx_complete), .tx_pin(tx_pin), .tx_drive(tx_drive), .irq(irq)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] d);
      exp_q.push_back(d);
      wr(1'b1, d);
   endtask

   task automatic wait_tick();
      do @(negedge clk); while (!baud_tick);
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) wait_tick();
   endtask

   // Monitor: decode frames on the pin and compare against the scoreboard
   initial begin
      logic [7:0] got;
      int gap;
      @(posedge rst_n);
      forever begin
         gap = 0;
         wait_tick();
         while (!(tx_drive && tx_pin == 1'b0)) begin
            gap++;
            wait_tick();
         end
         last_gap = gap;
         wait_ticks(7);
         check(tx_pin == 1'b0, "R2 start bit", int'(tx_pin), 0);
         for (int i = 0; i < 8; i++) begin
            wait_ticks(16);
            got[i] = tx_pin;
         end
         wait_ticks(16);
         check(tx_pin == 1'b1, "R2 stop bit", int'(tx_pin), 1);
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected frame", int'(got), -1);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(got == e, "R2 frame data", int'(got), int'(e));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ctrl_q == 8'h00, "R1 ctrl", int'(ctrl_q), 0);
      check(tdr_empty == 1'b1, "R1 empty", int'(tdr_empty), 1);
      check(tx_complete == 1'b1, "R1 done", int'(tx_complete), 1);
      check(irq == 1'b0, "R1 irq", int'(irq), 0);
      // R9 pin released
      check(tx_drive == 1'b0, "R9 drive", int'(tx_drive), 0);
      gpio_out = 1'b1; @(negedge clk);
      check(tx_pin == 1'b1, "R9 gpio high", int'(tx_pin), 1);
      gpio_out = 1'b0; @(negedge clk);
      check(tx_pin == 1'b0, "R9 gpio low", int'(tx_pin), 0);
      rx_enable = 1'b1; @(negedge clk);
      check(tx_drive == 1'b1 && tx_pin == 1'b1, "R9 rx claims pin", int'(tx_pin), 1);
      // R11 low bits
      wr(1'b0, 8'h07);
      check(ctrl_q == 8'h00, "R11 low bits", int'(ctrl_q), 0);
      // R3/R4 data write with transmitter off
      send_byte(8'hA5);
      check(tdr_empty == 1'b0, "R3 write clears empty", int'(tdr_empty), 0);
      check(tx_complete == 1'b0, "R4 write clears done", int'(tx_complete), 0);
      wait_ticks(40);
      check(tx_pin == 1'b1 && tdr_empty == 1'b0, "R3 no send while off", int'(tx_pin), 1);
      // R7 one bit of idle after enable
      wr(1'b0, 8'h08);
      n = 0;
      while (tx_pin != 1'b0) begin wait_tick(); n++; end
      check(n >= 15 && n <= 19, "R7 enable delay", n, 16);
      repeat (3) @(negedge clk);
      check(tdr_empty == 1'b1, "R3 load sets empty", int'(tdr_empty), 1);
      // R10 back-to-back
      send_byte(8'h3C);
      wait (exp_q.size() == 0);
      wait_ticks(10);
      check(last_gap >= 6 && last_gap <= 10, "R10 back-to-back gap", last_gap, 8);
      wait_ticks(170);
      check(tx_complete == 1'b1, "R4 done after stop", int'(tx_complete), 1);
      // R5/R6 interrupt combinations
      wr(1'b0, 8'h88); check(irq == 1'b1, "R5 empty term", int'(irq), 1);
      wr(1'b0, 8'h48); check(irq == 1'b1, "R5 done term", int'(irq), 1);
      wr(1'b0, 8'h08); check(irq == 1'b0, "R5 no enables", int'(irq), 0);
      rx_overrun = 1'b1; rx_full = 1'b1; rx_idle = 1'b1; @(negedge clk);
      check(irq == 1'b0, "R6 rx flags gated off", int'(irq), 0);
      rx_full = 1'b0; rx_idle = 1'b0;
      wr(1'b0, 8'h28); check(irq == 1'b1, "R6 overrun term", int'(irq), 1);
      rx_overrun = 1'b0; rx_full = 1'b1; @(negedge clk);
      check(irq == 1'b1, "R6 full term", int'(irq), 1);
      rx_full = 1'b0; @(negedge clk);
      check(irq == 1'b0, "R6 rx term idle", int'(irq), 0);
      wr(1'b0, 8'h18); rx_idle = 1'b1; @(negedge clk);
      check(irq == 1'b1, "R6 idle term", int'(irq), 1);
      rx_idle = 1'b0; @(negedge clk);
      check(irq == 1'b0, "R6 idle term off", int'(irq), 0);
      wr(1'b0, 8'h08);
      // R8 enable pulse mid-frame queues a preamble
      send_byte(8'h11);
      wait_ticks(40);
      wr(1'b0, 8'h00);
      wr(1'b0, 8'h08);
      send_byte(8'h22);
      wait (exp_q.size() == 0);
      wait_ticks(10);
      check(last_gap >= 165 && last_gap <= 172, "R8 preamble gap", last_gap, 168);
      wait_ticks(170);
      check(tx_complete == 1'b1, "R4 done at end", int'(tx_complete), 1);
      // R9 release again
      rx_enable = 1'b0; wr(1'b0, 8'h00); gpio_out = 1'b0; @(negedge clk);
      check(tx_drive == 1'b0 && tx_pin == 1'b0, "R9 released", int'(tx_pin), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule